// File: doc/BRIEF.md
# Clocked Serial Receiver with Overrun Lockout

This unit receives a synchronous serial stream one bit per rising edge of a serial clock. The clock comes from one of two places, picked by a control bit. In external mode an outside master drives the clock. In internal mode the unit takes a locally generated clock, uses it for sampling and drives it out to the far end. The clock and data inputs pass through a synchronizer, and the rising edge is detected in the system clock domain. Bits are collected least significant first. After eight edges, the byte moves into a data register for the host to read.

Two flags report the receive state: a data-full flag and an overrun flag. A byte that completes while the data-full flag is still set is not stored and raises the overrun flag instead. While overrun is flagged, the unit stops all traffic. Shifting stops, the internal clock output is parked high, and the transmit-permit output is dropped. This lasts until the host writes 0 to the overrun bit. One interrupt-enable bit gates both the data-ready and the error request outputs.

The host uses a small register port with write and read strobes and an address. Address 0 is control: bit0 receive enable, bit1 transmit enable, bit2 interrupt enable, bit3 internal clock select. Address 1 is status: bit0 data-full, bit1 overrun. Address 2 is the received byte and is read-only. Address 3 reads zero. Reads are combinational.

Top module: `sync_rx_unit`

## Requirements
- R1: With receive enabled, the synchronized data input is sampled at each synchronized rising serial clock edge. The first sampled bit lands in bit0 of the received byte and the eighth in bit7.
- R2: When the eighth bit arrives and the data-full flag (status bit0) is 0, the byte is written to the data register (address 2) and the data-full flag becomes 1.
- R3: When the eighth bit arrives while the data-full flag is 1, the overrun flag (status bit1) becomes 1 and the data register keeps its old value.
- R4: While overrun is 1, no bits are shifted and no byte completes, `tx_allow` is 0, and `sclk_out` is held at 1. Writing 0 to status bit1 clears overrun and restores operation.
- R5: A write of 0 to status bit0 clears the data-full flag only if the data register was read after the flag was set. Otherwise the flag stays 1.
- R6: Writing 1 to either status bit leaves that flag unchanged.
- R7: `rx_irq` equals data-full AND control bit2, and `err_irq` equals overrun AND control bit2.
- R8: With control bit0 at 0, no bits are shifted and a partly received byte is dropped. The next byte after re-enabling is assembled from its own first bit.
- R9: With control bit3 at 1, `sclk_int` clocks the receiver, `sclk_oe` is 1 and `sclk_out` follows `sclk_int` while receive is enabled. With bit3 at 0, `sclk_ext` clocks the receiver and `sclk_oe` is 0.
- R10: After reset, every control and status bit and the data register are 0, both interrupt outputs and `tx_allow` are 0, and `sclk_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| sclk_ext | input | 1 | Serial clock from an outside master |
| sclk_int | input | 1 | Locally generated serial clock |
| sclk_out | output | 1 | Serial clock driven out in internal mode |
| sclk_oe | output | 1 | Output enable for `sclk_out` |
| sdata_in | input | 1 | Serial data input |
| tx_allow | output | 1 | Transmit permitted (transmit enabled, no overrun) |
| rx_irq | output | 1 | Receive-data request |
| err_irq | output | 1 | Receive-error request |

## Verification
The bytes 0xA5, 0x01, 0x80 and 0x3C are received. The 0x01 and 0x80 pair exposes a reversed bit order or a shifted bit count, which a symmetric byte would hide. A second byte sent without clearing the flag, followed by a third byte sent during lockout, separates storing from overrun and shows whether lockout really stops shifting. A three-bit fragment cut off by disabling receive, a status clear attempted without a prior read, and the same byte carried on the internal clock input each exercise a path that normal reception never takes.

// File: rtl/sync_rx_pkg.sv
// Package: shared register addresses, field positions and the control
// record of the clocked serial receiver.
package sync_rx_pkg;
    localparam int REG_ADDR_W = 2;

    localparam logic [REG_ADDR_W-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_DATA   = 2'd2;

    localparam int CTRL_RX_EN  = 0;
    localparam int CTRL_TX_EN  = 1;
    localparam int CTRL_IRQ_EN = 2;
    localparam int CTRL_CLKINT = 3;

    localparam int STAT_FULL = 0;
    localparam int STAT_OVR  = 1;

    typedef struct packed {
        logic clk_int;
        logic irq_en;
        logic tx_en;
        logic rx_en;
    } ctrl_t;
endpackage

// File: rtl/sync_rx_edge.sv
// Module: sync_rx_edge
// Picks the serial clock source and passes clock and data through the
// same synchronizer chain, so both keep their alignment. Emits a
// one-cycle pulse on each rising serial clock edge, together with the
// data bit present at that edge.
// Assumes: every serial clock phase lasts at least two system clocks.
module sync_rx_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_int,
    input  logic sclk_ext,
    input  logic sclk_int,
    input  logic sdata_in,
    output logic rise,
    output logic bit_val
);
    localparam int LAST = SYNC_STAGES - 1;

    logic             sclk_sel;
    logic [LAST:0]    clk_chain;
    logic [LAST:0]    dat_chain;
    logic             clk_prev;

    // Source select ahead of the synchronizer.
    always_comb sclk_sel = use_int ? sclk_int : sclk_ext;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            // One synchronizer stage for clock and data.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    clk_chain[g] <= 1'b0;
                    dat_chain[g] <= 1'b0;
                end else if (g == 0) begin
                    clk_chain[g] <= sclk_sel;
                    dat_chain[g] <= sdata_in;
                end else begin
                    clk_chain[g] <= clk_chain[(g > 0) ? g-1 : 0];
                    dat_chain[g] <= dat_chain[(g > 0) ? g-1 : 0];
                end
            end
        end
    endgenerate

    // Previous synchronized clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= clk_chain[LAST];
    end

    // Rising edge pulse and the bit that goes with it.
    always_comb begin
        rise    = clk_chain[LAST] & ~clk_prev;
        bit_val = dat_chain[LAST];
    end

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R1
endmodule

// File: rtl/sync_rx_shifter.sv
// Module: sync_rx_shifter
// Collects bits least significant first. Raises a one-cycle done pulse
// with the full word once DATA_W bits have arrived. While inactive
// (receive off or locked) the bit count is held at zero, so a partial
// word is dropped and the next word begins at its own first bit.
module sync_rx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              rise,
    input  logic              bit_val,
    output logic              done,
    output logic [DATA_W-1:0] word
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              take;

    // A bit is taken only on an edge while active.
    always_comb take = active & rise;

    // Shift register: new bit enters at the top and moves down.
    always_ff @(posedge clk) begin
        if (!rst_n)    shreg <= '0;
        else if (take) shreg <= {bit_val, shreg[DATA_W-1:1]};
    end

    // Bit counter, cleared while inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)  cnt <= '0;
        else if (take)          cnt <= (cnt == LAST_BIT) ? '0 : cnt + 1'b1;
    end

    // Completion pulse and captured word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            word <= '0;
        end else begin
            done <= take && (cnt == LAST_BIT);
            if (take && (cnt == LAST_BIT)) word <= {bit_val, shreg[DATA_W-1:1]};
        end
    end

    AST_MSB_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> shreg[DATA_W-1] == $past(bit_val)); // R1
    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> cnt == '0 && !done); // R8
endmodule

// File: rtl/sync_rx_regs.sv
// Module: sync_rx_regs
// Host register file: control, status flags and received data.
// Stores a completed word or raises overrun, applies the
// write-zero-to-clear rules (with the read-before-clear condition on
// data-full), and produces lockout, interrupt and clock-out controls.
// Assumes: a completion and a status clear do not fall in one cycle;
// if they do, the completion wins.
module sync_rx_regs
    import sync_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  done,
    input  logic [DATA_W-1:0]     word,
    output ctrl_t                 ctrl,
    output logic                  full,
    output logic                  ovr,
    output logic                  rx_active,
    output logic                  rx_irq,
    output logic                  err_irq,
    output logic                  tx_allow
);
    logic [DATA_W-1:0] data_q;
    logic              rd_seen;
    logic              wr_ctrl, wr_stat, rd_data;

    // Access decode.
    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
        wr_stat = reg_wr && (reg_addr == ADDR_STATUS);
        rd_data = reg_rd && (reg_addr == ADDR_DATA);
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= ctrl_t'(reg_wdata[3:0]);
    end

    // Received data register, loaded only into an empty slot.
    always_ff @(posedge clk) begin
        if (!rst_n)              data_q <= '0;
        else if (done && !full)  data_q <= word;
    end

    // Data-full flag: set on store, cleared by write 0 after a read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         full <= 1'b0;
        else if (done && !full)                             full <= 1'b1;
        else if (wr_stat && !reg_wdata[STAT_FULL] && rd_seen) full <= 1'b0;
    end

    // Tracks a data read since data-full was last set.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   rd_seen <= 1'b0;
        else if (done && !full)                       rd_seen <= 1'b0;
        else if (wr_stat && !reg_wdata[STAT_FULL])    rd_seen <= 1'b0;
        else if (rd_data && full)                     rd_seen <= 1'b1;
    end

    // Overrun flag: set on completion while full, cleared by write 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                               ovr <= 1'b0;
        else if (done && full)                    ovr <= 1'b1;
        else if (wr_stat && !reg_wdata[STAT_OVR]) ovr <= 1'b0;
    end

    // Derived controls and requests.
    always_comb begin
        rx_active = ctrl.rx_en & ~ovr;
        rx_irq    = full & ctrl.irq_en;
        err_irq   = ovr & ctrl.irq_en;
        tx_allow  = ctrl.tx_en & ~ovr;
    end

    // Read data mux.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL:   reg_rdata[3:0] = ctrl;
            ADDR_STATUS: begin
                reg_rdata[STAT_FULL] = full;
                reg_rdata[STAT_OVR]  = ovr;
            end
            ADDR_DATA:   reg_rdata = data_q;
            default:     reg_rdata = '0;
        endcase
    end

    AST_STORE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        done && !full |=> full && data_q == $past(word)); // R2
    AST_OVERRUN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        done && full |=> ovr && $stable(data_q)); // R3
    AST_LOCK_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovr) && ovr |-> !done); // R4
    AST_SET_ONE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat && reg_wdata[STAT_FULL] && reg_wdata[STAT_OVR] && !done
        |=> full == $past(full) && ovr == $past(ovr)); // R6
endmodule

// File: rtl/sync_rx_unit.sv
// Module: sync_rx_unit (top)
// Clocked serial receiver with overrun lockout. Ties together the edge
// detector, the shifter and the register file, and drives the serial
// clock out in internal mode.
// Assumes: the host clears data-full in time, or accepts the lockout.
module sync_rx_unit
    import sync_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  sclk_ext,
    input  logic                  sclk_int,
    output logic                  sclk_out,
    output logic                  sclk_oe,
    input  logic                  sdata_in,
    output logic                  tx_allow,
    output logic                  rx_irq,
    output logic                  err_irq
);
    ctrl_t             ctrl;
    logic              full, ovr, rx_active;
    logic              rise, bit_val, done;
    logic [DATA_W-1:0] word;

    sync_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk(clk), .rst_n(rst_n), .use_int(ctrl.clk_int),
        .sclk_ext(sclk_ext), .sclk_int(sclk_int), .sdata_in(sdata_in),
        .rise(rise), .bit_val(bit_val)
    );

    sync_rx_shifter #(.DATA_W(DATA_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .active(rx_active), .rise(rise),
        .bit_val(bit_val), .done(done), .word(word)
    );

    sync_rx_regs #(.DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .done(done), .word(word), .ctrl(ctrl), .full(full), .ovr(ovr),
        .rx_active(rx_active), .rx_irq(rx_irq), .err_irq(err_irq),
        .tx_allow(tx_allow)
    );

    // Serial clock out: follows the internal clock while receiving,
    // parked high otherwise.
    always_comb begin
        sclk_oe  = ctrl.clk_int;
        sclk_out = (ctrl.clk_int && rx_active) ? sclk_int : 1'b1;
    end

    AST_LOCK_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> sclk_out && !tx_allow); // R4
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.irq_en |-> !rx_irq && !err_irq); // R7
endmodule

// File: tb/sync_rx_unit_tb_top.sv
module sync_rx_unit_tb_top;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       sclk_ext = 1'b0, sclk_int = 1'b0, sdata_in = 1'b0;
    logic       sclk_out, sclk_oe, tx_allow, rx_irq, err_irq;

    int checks = 0;
    int errors = 0;

    sync_rx_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk_ext(sclk_ext), .sclk_int(sclk_int), .sclk_out(sclk_out),
        .sclk_oe(sclk_oe), .sdata_in(sdata_in), .tx_allow(tx_allow),
        .rx_irq(rx_irq), .err_irq(err_irq)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Sends the lowest nbits of b, LSB first, on the chosen clock input.
    task automatic send(input logic [7:0] b, input int nbits, input bit on_int);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            sdata_in = b[i];
            idle(HALF);
            if (on_int) sclk_int = 1'b1; else sclk_ext = 1'b1;
            idle(HALF);
            if (on_int) sclk_int = 1'b0; else sclk_ext = 1'b0;
        end
        idle(8);
    endtask

    // Reads data then writes 0 to both status bits.
    task automatic drain(output logic [7:0] d);
        rd(2'd2, d);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(2'd0, v); check(v == 8'h00, "R10 ctrl", v, 0);
        rd(2'd1, v); check(v == 8'h00, "R10 status", v, 0);
        rd(2'd2, v); check(v == 8'h00, "R10 data", v, 0);
        check({rx_irq, err_irq, tx_allow, sclk_out} == 4'b0001, "R10 outputs",
              {rx_irq, err_irq, tx_allow, sclk_out}, 1);
    endtask

    task automatic t_basic;
        logic [7:0] v;
        wr(2'd0, 8'h07);
        send(8'hA5, 8, 1'b0);
        rd(2'd1, v); check(v == 8'h01, "R2 full set", v, 1);
        rd(2'd2, v); check(v == 8'hA5, "R2 data", v, 8'hA5);
        check(rx_irq == 1'b1 && err_irq == 1'b0, "R7 rx_irq", {rx_irq, err_irq}, 2);
        check(sclk_oe == 1'b0, "R9 ext oe", sclk_oe, 0);
        wr(2'd1, 8'h00);
        rd(2'd1, v); check(v == 8'h00, "R5 clear after read", v, 0);
    endtask

    task automatic t_order;
        logic [7:0] v;
        send(8'h01, 8, 1'b0); drain(v);
        check(v == 8'h01, "R1 first bit to bit0", v, 1);
        send(8'h80, 8, 1'b0); drain(v);
        check(v == 8'h80, "R1 last bit to bit7", v, 8'h80);
    endtask

    task automatic t_clear_rules;
        logic [7:0] v;
        send(8'h3C, 8, 1'b0);
        wr(2'd1, 8'h00);
        rd(2'd1, v); check(v[0] == 1'b1, "R5 no clear without read", v, 1);
        wr(2'd1, 8'hFF);
        rd(2'd1, v); check(v == 8'h01, "R6 write one no effect", v, 1);
        drain(v);
        rd(2'd1, v); check(v == 8'h00, "R5 clear after read", v, 0);
    endtask

    task automatic t_overrun;
        logic [7:0] v;
        send(8'h11, 8, 1'b0);
        send(8'h22, 8, 1'b0);
        rd(2'd1, v); check(v == 8'h03, "R3 overrun set", v, 3);
        rd(2'd2, v); check(v == 8'h11, "R3 data kept", v, 8'h11);
        check(err_irq == 1'b1 && tx_allow == 1'b0, "R4 err_irq/tx", {err_irq, tx_allow}, 2);
        wr(2'd1, 8'h02);
        rd(2'd1, v); check(v == 8'h02, "R4 full cleared, ovr held", v, 2);
        wr(2'd1, 8'hFF);
        rd(2'd1, v); check(v == 8'h02, "R6 ovr write one", v, 2);
        send(8'h33, 8, 1'b0);
        rd(2'd1, v); check(v == 8'h02, "R4 no shift while locked", v, 2);
        wr(2'd1, 8'h00);
        check(tx_allow == 1'b1 && err_irq == 1'b0, "R4 resume", {tx_allow, err_irq}, 2);
        send(8'h44, 8, 1'b0); drain(v);
        check(v == 8'h44, "R4 receive after clear", v, 8'h44);
    endtask

    task automatic t_irq_off;
        logic [7:0] v;
        wr(2'd0, 8'h03);
        send(8'h5A, 8, 1'b0);
        check(rx_irq == 1'b0, "R7 gated off", rx_irq, 0);
        drain(v);
        check(v == 8'h5A, "R2 data irq off", v, 8'h5A);
    endtask

    task automatic t_disable;
        logic [7:0] v;
        send(8'h07, 3, 1'b0);
        wr(2'd0, 8'h00);
        send(8'hFF, 8, 1'b0);
        rd(2'd1, v); check(v == 8'h00, "R8 no shift disabled", v, 0);
        wr(2'd0, 8'h07);
        send(8'h96, 8, 1'b0); drain(v);
        check(v == 8'h96, "R8 fragment dropped", v, 8'h96);
    endtask

    task automatic t_internal;
        logic [7:0] v;
        wr(2'd0, 8'h0F);
        check(sclk_oe == 1'b1, "R9 oe", sclk_oe, 1);
        @(negedge clk); sclk_int = 1'b0; #1;
        check(sclk_out == 1'b0, "R9 follows low", sclk_out, 0);
        sclk_int = 1'b1; #1;
        check(sclk_out == 1'b1, "R9 follows high", sclk_out, 1);
        sclk_int = 1'b0;
        send(8'hC3, 8, 1'b1); drain(v);
        check(v == 8'hC3, "R9 internal receive", v, 8'hC3);
        send(8'h0F, 8, 1'b0);
        rd(2'd1, v); check(v == 8'h00, "R9 ext ignored in int", v, 0);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_basic();
        t_order();
        t_clear_rules();
        t_overrun();
        t_irq_off();
        t_disable();
        t_internal();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule